// File: doc/BRIEF.md
# Window Watchdog with Error Accumulator

This block supervises a processor by timing the refresh events the processor sends it. A counter measures the clock cycles since the last refresh. Each new refresh is sorted into one of three classes. A refresh that comes too soon is early. One that comes after the open window is late. Any other refresh is good. If the counter reaches a terminal limit and no refresh has arrived, the block starts a system reset straight away.

Early and late refreshes do not cause a reset on their own. Each one raises an error level by one. Each good refresh lowers the level by one. A reset starts only when the level climbs to a programmable threshold, so a single timing slip is absorbed and a steady stream of slips is not.

After a fatal condition, the reset output waits for a programmable delay and is then held for a programmable number of cycles. When it releases, the watchdog starts again from a clean state. Sticky flags record which kinds of fault have occurred. Software clears them with a write-one-to-clear strobe.

Top module: `wwdt_guard`

## Requirements
- R1: `edge_mode` selects which transition of `refresh_in` counts as a refresh. 2'b00 selects a rising edge only, 2'b01 a falling edge only, and 2'b10 or 2'b11 selects both edges. A transition of the unselected kind has no effect. The level of `refresh_in` during reset is taken as its starting value.
- R2: The interval count restarts at zero on every refresh, whether the refresh is good or not. A refresh sampled at a clock edge where the count is below `lim_early` is early. It sets `early_flag` in the following cycle. When a transition is driven W cycles after the previous refresh was sampled, or W cycles after reset is released, the count seen by that transition is W.
- R3: A refresh seen with a count above `lim_late` is late and sets `late_flag`. This includes a count equal to `lim_term`. A count from `lim_early` to `lim_late` inclusive is good.
- R4: If the count reaches `lim_term` with no refresh at that edge, `term_flag` is set and the reset sequence starts, whatever the error level is.
- R5: Each early or late refresh raises `err_count` by one. Each good refresh lowers it by one, and it never goes below zero. The new value appears in the cycle after the refresh.
- R6: When an early or late refresh brings the error level to `err_limit` or above, the reset sequence starts.
- R7: `sys_rst_o` rises `rst_delay`+1 cycles after the clock edge that detects the fatal condition.
- R8: `sys_rst_o` stays high for `rst_len` cycles, with a minimum of one. It falls together with a clear of both the interval count and the error level. Refreshes that arrive between detection and release are ignored.
- R9: The sticky flags sit at bit 0 (early), bit 1 (late) and bit 2 (term). A one on the matching bit of `flag_clr` clears a flag in the next cycle. A new event in the same cycle wins over the clear.
- R10: A synchronous `rst` drives all outputs low and sets `err_count` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| refresh_in | input | 1 | Refresh signal from the supervised processor |
| edge_mode | input | 2 | Edge select: 00 rise, 01 fall, 1x both |
| lim_early | input | CNT_W | Lowest count at which a refresh is accepted |
| lim_late | input | CNT_W | Highest count at which a refresh is on time |
| lim_term | input | CNT_W | Count at which a missing refresh is fatal |
| err_limit | input | ACC_W | Error level that triggers a reset |
| rst_delay | input | DLY_W | Cycles between detection and reset assertion, less one |
| rst_len | input | DLY_W | Reset pulse length in cycles |
| flag_clr | input | 3 | Write-one-to-clear strobe for the sticky flags |
| sys_rst_o | output | 1 | System reset request |
| early_flag | output | 1 | Sticky early-refresh flag |
| late_flag | output | 1 | Sticky late-refresh flag |
| term_flag | output | 1 | Sticky terminal-timeout flag |
| err_count | output | ACC_W | Current error level |

## Verification
A wrong interval count shows up at the first refresh that lands on a window boundary. Refreshes at counts exactly `lim_early`-1, `lim_early`, `lim_late`, `lim_term` and one past `lim_term` reveal it one cycle after the edge, through the flags. A wrong error level is visible on `err_count` in the cycle after each refresh, and its decrement floor shows after repeated good refreshes. A fault in the sequencer shows at the exact cycle where `sys_rst_o` rises and falls. A refresh that leaks through during the delay shows as an `err_count` change while the reset is pending. A count that was not cleared makes the first refresh after release come out late or fatal instead of good.

// File: rtl/wwdt_pkg.sv
package wwdt_pkg;
  // refresh edge selection codes
  localparam logic [1:0] EDGE_RISE = 2'b00;
  localparam logic [1:0] EDGE_FALL = 2'b01;

  // sticky flag positions
  localparam int FLAG_EARLY = 0;
  localparam int FLAG_LATE  = 1;
  localparam int FLAG_TERM  = 2;
  localparam int FLAG_N     = 3;

  typedef enum logic [1:0] {
    SQ_RUN  = 2'b00,
    SQ_WAIT = 2'b01,
    SQ_HOLD = 2'b10
  } seq_state_e;
endpackage

// File: rtl/wwdt_edge.sv
module wwdt_edge (
  input  logic       clk,
  input  logic       din,
  input  logic [1:0] mode,
  output logic       hit
);
  import wwdt_pkg::*;

  logic last_q;

  // tracks the line at all times, including reset, so the reset level is the baseline
  always_ff @(posedge clk) last_q <= din;

  always_comb begin
    case (mode)
      EDGE_RISE: hit = din & ~last_q;
      EDGE_FALL: hit = ~din & last_q;
      default:   hit = din ^ last_q;
    endcase
  end
endmodule

// File: rtl/wwdt_window.sv
module wwdt_window #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             restart,
  input  logic             hit,
  input  logic [CNT_W-1:0] lo,
  input  logic [CNT_W-1:0] hi,
  input  logic [CNT_W-1:0] term,
  output logic             ev_early,
  output logic             ev_late,
  output logic             ev_good,
  output logic             ev_term
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q;

  always_comb begin
    ev_early = 1'b0;
    ev_late  = 1'b0;
    ev_good  = 1'b0;
    ev_term  = 1'b0;
    if (run) begin
      if (hit) begin
        if (cnt_q < lo)      ev_early = 1'b1;
        else if (cnt_q > hi) ev_late  = 1'b1;
        else                 ev_good  = 1'b1;
      end else if (cnt_q >= term) begin
        ev_term = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || restart)      cnt_q <= '0;
    else if (run) begin
      if (hit)               cnt_q <= '0;
      else if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/wwdt_accum.sv
module wwdt_accum #(
  parameter int ACC_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             up,
  input  logic             down,
  input  logic [ACC_W-1:0] limit,
  output logic [ACC_W-1:0] level,
  output logic             trip
);
  localparam logic [ACC_W-1:0] LVL_MAX = '1;

  logic [ACC_W-1:0] lvl_q, lvl_nxt;

  always_comb begin
    lvl_nxt = lvl_q;
    if (up && lvl_q != LVL_MAX)    lvl_nxt = lvl_q + 1'b1;
    else if (down && lvl_q != '0)  lvl_nxt = lvl_q - 1'b1;
    trip = up && (lvl_nxt >= limit);
  end

  always_ff @(posedge clk) begin
    if (rst || clear) lvl_q <= '0;
    else              lvl_q <= lvl_nxt;
  end

  assign level = lvl_q;
endmodule

// File: rtl/wwdt_guard.sv
module wwdt_guard #(
  parameter int CNT_W = 16,
  parameter int ACC_W = 4,
  parameter int DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             refresh_in,
  input  logic [1:0]       edge_mode,
  input  logic [CNT_W-1:0] lim_early,
  input  logic [CNT_W-1:0] lim_late,
  input  logic [CNT_W-1:0] lim_term,
  input  logic [ACC_W-1:0] err_limit,
  input  logic [DLY_W-1:0] rst_delay,
  input  logic [DLY_W-1:0] rst_len,
  input  logic [2:0]       flag_clr,
  output logic             sys_rst_o,
  output logic             early_flag,
  output logic             late_flag,
  output logic             term_flag,
  output logic [ACC_W-1:0] err_count
);
  import wwdt_pkg::*;

  seq_state_e       state_q;
  logic [DLY_W-1:0] tmr_q;
  logic             busy, hold_done, restart, fatal;
  logic             hit, ev_early, ev_late, ev_good, ev_term, trip;
  logic [FLAG_N-1:0] flag_set, flags_q;

  assign busy      = (state_q != SQ_RUN);
  assign hold_done = ({1'b0, tmr_q} + 1'b1) >= {1'b0, rst_len};
  assign restart   = (state_q == SQ_HOLD) && hold_done;
  assign fatal     = ev_term | trip;

  wwdt_edge u_edge (
    .clk  (clk),
    .din  (refresh_in),
    .mode (edge_mode),
    .hit  (hit)
  );

  wwdt_window #(.CNT_W(CNT_W)) u_window (
    .clk      (clk),
    .rst      (rst),
    .run      (!busy),
    .restart  (restart),
    .hit      (hit),
    .lo       (lim_early),
    .hi       (lim_late),
    .term     (lim_term),
    .ev_early (ev_early),
    .ev_late  (ev_late),
    .ev_good  (ev_good),
    .ev_term  (ev_term)
  );

  wwdt_accum #(.ACC_W(ACC_W)) u_accum (
    .clk   (clk),
    .rst   (rst),
    .clear (restart),
    .up    (ev_early | ev_late),
    .down  (ev_good),
    .limit (err_limit),
    .level (err_count),
    .trip  (trip)
  );

  // reset sequencer: detection -> delay -> held pulse -> clean restart
  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= SQ_RUN;
      tmr_q     <= '0;
      sys_rst_o <= 1'b0;
    end else begin
      case (state_q)
        SQ_RUN: begin
          if (fatal) begin
            state_q <= SQ_WAIT;
            tmr_q   <= '0;
          end
        end
        SQ_WAIT: begin
          if (tmr_q == rst_delay) begin
            state_q   <= SQ_HOLD;
            tmr_q     <= '0;
            sys_rst_o <= 1'b1;
          end else begin
            tmr_q <= tmr_q + 1'b1;
          end
        end
        SQ_HOLD: begin
          if (hold_done) begin
            state_q   <= SQ_RUN;
            tmr_q     <= '0;
            sys_rst_o <= 1'b0;
          end else begin
            tmr_q <= tmr_q + 1'b1;
          end
        end
        default: begin
          state_q   <= SQ_RUN;
          tmr_q     <= '0;
          sys_rst_o <= 1'b0;
        end
      endcase
    end
  end

  // sticky flags, set has priority over clear
  always_comb begin
    flag_set             = '0;
    flag_set[FLAG_EARLY] = ev_early;
    flag_set[FLAG_LATE]  = ev_late;
    flag_set[FLAG_TERM]  = ev_term;
  end

  for (genvar g = 0; g < FLAG_N; g++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst) flags_q[g] <= 1'b0;
      else     flags_q[g] <= flag_set[g] | (flags_q[g] & ~flag_clr[g]);
    end
  end

  assign early_flag = flags_q[FLAG_EARLY];
  assign late_flag  = flags_q[FLAG_LATE];
  assign term_flag  = flags_q[FLAG_TERM];
endmodule

// File: rtl/wwdt_guard_chk.sv
module wwdt_guard_chk #(
  parameter int ACC_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             sys_rst_o,
  input logic             busy,
  input logic             ev_early,
  input logic             ev_term,
  input logic             early_flag,
  input logic [2:0]       flag_clr,
  input logic [ACC_W-1:0] err_count
);
  // R9: an early event is always recorded
  p_flag_set_r9: assert property (@(posedge clk) disable iff (rst)
    ev_early |=> early_flag);

  // R9: a clear without a fresh event empties the flag
  p_flag_clear_r9: assert property (@(posedge clk) disable iff (rst)
    (flag_clr[0] && !ev_early) |=> !early_flag);

  // R4: a terminal timeout enters the delay phase
  p_term_seq_r4: assert property (@(posedge clk) disable iff (rst)
    ev_term |=> (busy && !sys_rst_o));

  // R5: the error level moves by at most one, except at release
  p_acc_step_r5: assert property (@(posedge clk) disable iff (rst)
    (err_count != $past(err_count)) |->
      ((err_count == $past(err_count) + 1'b1) ||
       (err_count == $past(err_count) - 1'b1) || $fell(sys_rst_o)));

  // R8: the reset output only appears during the sequence
  p_rst_in_seq_r8: assert property (@(posedge clk) disable iff (rst)
    sys_rst_o |-> busy);

  // R8: refreshes during the sequence leave the level untouched
  p_frozen_r8: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(err_count));
endmodule

bind wwdt_guard wwdt_guard_chk #(.ACC_W(ACC_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .sys_rst_o  (sys_rst_o),
  .busy       (busy),
  .ev_early   (ev_early),
  .ev_term    (ev_term),
  .early_flag (early_flag),
  .flag_clr   (flag_clr),
  .err_count  (err_count)
);

// File: tb/wwdt_guard_test.sv
`timescale 1ns/1ps
module wwdt_guard_test;
  localparam int CNT_W = 16;
  localparam int ACC_W = 4;
  localparam int DLY_W = 8;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             rf = 1'b0;
  logic [1:0]       mode = 2'b10;
  logic [CNT_W-1:0] lo = 16'd4, hi = 16'd8, tm = 16'd12;
  logic [ACC_W-1:0] lim = 4'd15;
  logic [DLY_W-1:0] dly = 8'd2, len = 8'd3;
  logic [2:0]       clr = 3'b000;
  logic             sys_rst_o, early_flag, late_flag, term_flag;
  logic [ACC_W-1:0] err_count;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  wwdt_guard #(.CNT_W(CNT_W), .ACC_W(ACC_W), .DLY_W(DLY_W)) uut (
    .clk (clk), .rst (rst), .refresh_in (rf), .edge_mode (mode),
    .lim_early (lo), .lim_late (hi), .lim_term (tm), .err_limit (lim),
    .rst_delay (dly), .rst_len (len), .flag_clr (clr),
    .sys_rst_o (sys_rst_o), .early_flag (early_flag), .late_flag (late_flag),
    .term_flag (term_flag), .err_count (err_count)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rf  = 1'b0;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  // toggle after w idle cycles; the design sees a count of w
  task automatic pulse_at(input int w);
    repeat (w) @(negedge clk);
    rf = ~rf;
    @(negedge clk);
  endtask

  task automatic lvl_at(input int w, input logic v);
    repeat (w) @(negedge clk);
    rf = v;
    @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset();
    check("R10", "sys_rst_o", sys_rst_o, 0);
    check("R10", "flags", {term_flag, late_flag, early_flag}, 0);
    check("R10", "err_count", err_count, 0);
  endtask

  task automatic t_good();
    mode = 2'b10; lim = 4'd15;
    do_reset();
    pulse_at(6);
    check("R2", "mid window early", early_flag, 0);
    pulse_at(4);
    check("R2", "count at lower limit early", early_flag, 0);
    pulse_at(8);
    check("R3", "count at upper limit late", late_flag, 0);
    check("R3", "good err", err_count, 0);
  endtask

  task automatic t_early();
    pulse_at(3);
    check("R2", "count below lower limit early", early_flag, 1);
    check("R5", "err after early", err_count, 1);
    pulse_at(6);
    check("R5", "err after good", err_count, 0);
    pulse_at(6);
    check("R5", "err floor at zero", err_count, 0);
  endtask

  task automatic t_late();
    pulse_at(9);
    check("R3", "count above upper limit", late_flag, 1);
    check("R5", "err after late", err_count, 1);
    pulse_at(12);
    check("R3", "err after refresh at terminal", err_count, 2);
    check("R4", "no terminal when refreshed", term_flag, 0);
    check("R4", "no reset when refreshed", sys_rst_o, 0);
    pulse_at(7);
    check("R5", "err after good", err_count, 1);
  endtask

  task automatic t_flags();
    clr = 3'b001;
    @(negedge clk);
    clr = 3'b000;
    check("R9", "early cleared", early_flag, 0);
    check("R9", "late kept", late_flag, 1);
    repeat (2) @(negedge clk);
    rf = ~rf;
    clr = 3'b001;
    @(negedge clk);
    clr = 3'b000;
    check("R9", "set wins over clear", early_flag, 1);
    clr = 3'b111;
    @(negedge clk);
    clr = 3'b000;
    check("R9", "all cleared", {term_flag, late_flag, early_flag}, 0);
  endtask

  task automatic t_threshold();
    mode = 2'b10; lim = 4'd3; dly = 8'd2; len = 8'd3;
    do_reset();
    pulse_at(2);
    check("R6", "err 1", err_count, 1);
    pulse_at(2);
    check("R6", "err 2 no reset", sys_rst_o, 0);
    pulse_at(2);
    check("R6", "err at limit", err_count, 3);
    check("R7", "reset not yet", sys_rst_o, 0);
    rf = ~rf;
    @(negedge clk);
    @(negedge clk);
    check("R7", "reset still low after delay-1", sys_rst_o, 0);
    @(negedge clk);
    check("R7", "reset rises after delay+1", sys_rst_o, 1);
    check("R8", "refresh in delay ignored", err_count, 3);
    repeat (2) @(negedge clk);
    check("R8", "reset held", sys_rst_o, 1);
    @(negedge clk);
    check("R8", "reset released after len", sys_rst_o, 0);
    check("R8", "err cleared on release", err_count, 0);
    pulse_at(5);
    check("R8", "count cleared on release", late_flag, 0);
    check("R8", "no terminal after release", term_flag, 0);
    check("R8", "good after release", err_count, 0);
  endtask

  task automatic t_delay0();
    lim = 4'd1; dly = 8'd0; len = 8'd1;
    do_reset();
    pulse_at(2);
    check("R7", "zero delay not yet", sys_rst_o, 0);
    @(negedge clk);
    check("R7", "zero delay rise", sys_rst_o, 1);
    @(negedge clk);
    check("R8", "one cycle pulse", sys_rst_o, 0);
  endtask

  task automatic t_terminal();
    lim = 4'd15; dly = 8'd2; len = 8'd3;
    do_reset();
    pulse_at(3);
    check("R4", "err below limit", err_count, 1);
    repeat (12) @(negedge clk);
    check("R4", "no terminal at count limit-1", term_flag, 0);
    @(negedge clk);
    check("R4", "terminal flag", term_flag, 1);
    check("R4", "err unchanged", err_count, 1);
    repeat (2) @(negedge clk);
    check("R4", "reset pending", sys_rst_o, 0);
    @(negedge clk);
    check("R4", "reset asserted", sys_rst_o, 1);
    repeat (3) @(negedge clk);
    check("R8", "released", sys_rst_o, 0);
    check("R8", "err cleared", err_count, 0);
  endtask

  task automatic t_modes();
    lim = 4'd15;
    mode = 2'b00;
    do_reset();
    lvl_at(6, 1'b1);
    lvl_at(0, 1'b0);
    check("R1", "rise mode ignores fall", early_flag, 0);
    check("R1", "rise mode err", err_count, 0);
    lvl_at(1, 1'b1);
    check("R1", "rise mode counts rise", early_flag, 1);
    mode = 2'b01;
    do_reset();
    lvl_at(3, 1'b1);
    lvl_at(2, 1'b0);
    check("R1", "fall mode ignores rise", early_flag, 0);
    check("R1", "fall mode err", err_count, 0);
    lvl_at(1, 1'b1);
    lvl_at(1, 1'b0);
    check("R1", "fall mode counts fall", early_flag, 1);
    mode = 2'b10;
  endtask

  initial begin
    t_reset();
    t_good();
    t_early();
    t_late();
    t_flags();
    t_threshold();
    t_delay0();
    t_terminal();
    t_modes();
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule